// File: doc/BRIEF.md
# Priority Address Window Translator

This block maps addresses seen on a local bus onto PCI bus addresses. It holds three programmable windows, each made of a base register and a map register. The two memory windows have a power-of-two span between 1 MB and 2 GB, and each carries its own PCI cycle-type code and an address-low pass-through flag. The third window carries I/O cycles over a fixed 16 MB span.

A lookup presents a local address with a valid strobe. The registered result comes out one cycle later. It gives the translated PCI address, the cycle type, the address-low flag and a hit bit. Windows may overlap. When they do, the lowest-numbered enabled window that covers the address decides the translation. Software can use this to enlarge one window for a while so that it hides the next one, and then reprogram the hidden window.

Top module: `addr_window_xlate`

## Requirements
- R1: After synchronous reset every window is disabled and out_valid is low, so any lookup made right after reset misses.
- R2: A lookup on in_valid produces out_valid exactly one cycle later. out_valid is low in every cycle that follows a cycle without in_valid.
- R3: Memory window w is enabled by bit 0 of its base register. Bits 31:20 of the base give the local start address. Bits 7:4 give a size code n, and the span is 1 MB shifted left by n. Codes 12 to 15 act as code 11 (2 GB). Base address bits below the span are ignored, so the window is aligned to its span.
- R4: On a memory-window hit, the PCI address takes the bits above the span from map bits 15:4 (as PCI bits 31:20) and the bits below the span from the local address.
- R5: The cycle type output comes from map bits 3:1. The codes are 000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration and 110 memory multiple.
- R6: Map bit 0 is the address-low flag and appears on out_adlow. When it is clear, PCI address bits 1:0 are zero. When it is set, they equal local address bits 1:0.
- R7: Windows are tried in the order memory 0, memory 1, I/O. The first enabled window that contains the address is used, even when a later window also matches.
- R8: The I/O window (index 2) is enabled by base bit 0. It matches when local bits 31:24 equal base bits 15:8, and it then outputs map bits 15:8 as PCI bits 31:24 with local bits 23:0 below them. Its cycle type is 001 and out_adlow is 1.
- R9: When no enabled window matches, or in_valid was low, out_hit is low and out_addr, out_type and out_adlow are zero. A disabled window never matches.
- R10: A write with reg_we high stores reg_wdata at the next edge. reg_sel selects the register: 0 base0, 1 map0, 2 base1, 3 map1, 4 I/O base, 5 I/O map. Map and I/O registers keep only wdata bits 15:0. A lookup in the same cycle as a write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_hit | output | 1 | An enabled window matched |
| out_addr | output | 32 | Translated PCI address |
| out_type | output | 3 | PCI cycle type code |
| out_adlow | output | 1 | Address-low pass-through flag of the winning window |

## Verification
The hardest case to reach from the ports is an address that two enabled windows cover at once. Only this case exposes the priority order and the masking of base bits below the span. The stimulus programs window 1 first. It then enlarges window 0 so that it covers window 1, and later shrinks it back, writing stray low base bits while it does so. Lookups in each of these phases go to the shared region and to its edges. A random sweep over addresses near every window boundary follows, checked each clock against a behavioural range model in the bench.

// File: rtl/win_pkg.sv
package win_pkg;

    localparam int ADDR_W        = 32;
    localparam int MAP_W         = 16;
    localparam int MB_SHIFT      = 20;
    localparam int IO_SHIFT      = 24;
    localparam int MAX_SIZE_CODE = 11;
    localparam int TYPE_W        = 3;

    typedef enum logic [TYPE_W-1:0] {
        CYC_IACK    = 3'b000,
        CYC_IO      = 3'b001,
        CYC_MEM     = 3'b011,
        CYC_CFG     = 3'b101,
        CYC_MEMMULT = 3'b110
    } cyc_code_t;

    typedef struct packed {
        logic              hit;
        logic [ADDR_W-1:0] addr;
        logic [TYPE_W-1:0] cyc;
        logic              adlow;
    } xlat_t;

    // Mask of the address bits above a memory window's span.
    function automatic logic [ADDR_W-1:0] span_mask(input logic [3:0] code);
        int unsigned c;
        c = (int'(code) > MAX_SIZE_CODE) ? MAX_SIZE_CODE : int'(code);
        return ~((ADDR_W'(1) << (MB_SHIFT + c)) - ADDR_W'(1));
    endfunction

endpackage

// File: rtl/win_regs.sv
module win_regs
    import win_pkg::*;
#(
    parameter int NUM_MEM = 2,
    parameter int SEL_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [SEL_W-1:0]               sel,
    input  logic [ADDR_W-1:0]              wdata,
    output logic [NUM_MEM-1:0][ADDR_W-1:0] mem_base,
    output logic [NUM_MEM-1:0][MAP_W-1:0]  mem_map,
    output logic [MAP_W-1:0]               io_base,
    output logic [MAP_W-1:0]               io_map
);
    localparam int IO_BASE_SEL = 2 * NUM_MEM;
    localparam int IO_MAP_SEL  = 2 * NUM_MEM + 1;

    for (genvar w = 0; w < NUM_MEM; w++) begin : g_mem
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_base[w] <= '0;
                mem_map[w]  <= '0;
            end else if (we) begin
                if (int'(sel) == 2 * w)     mem_base[w] <= wdata;
                if (int'(sel) == 2 * w + 1) mem_map[w]  <= wdata[MAP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_base <= '0;
            io_map  <= '0;
        end else if (we) begin
            if (int'(sel) == IO_BASE_SEL) io_base <= wdata[MAP_W-1:0];
            if (int'(sel) == IO_MAP_SEL)  io_map  <= wdata[MAP_W-1:0];
        end
    end

endmodule

// File: rtl/win_mem_match.sv
module win_mem_match
    import win_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [MAP_W-1:0]  map,
    input  logic [ADDR_W-1:0] addr,
    output xlat_t             res
);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] pci;
    logic              match;

    always_comb begin
        mask      = span_mask(base[7:4]);
        base_addr = {base[ADDR_W-1:MB_SHIFT], {MB_SHIFT{1'b0}}};
        map_addr  = {map[MAP_W-1:4], {MB_SHIFT{1'b0}}};
        match     = base[0] && (((addr ^ base_addr) & mask) == '0);
        pci       = (map_addr & mask) | (addr & ~mask);
        if (!map[0]) pci[1:0] = 2'b00;
        res = '0;
        if (match) begin
            res.hit   = 1'b1;
            res.addr  = pci;
            res.cyc   = map[3:1];
            res.adlow = map[0];
        end
    end

endmodule

// File: rtl/win_io_match.sv
module win_io_match
    import win_pkg::*;
(
    input  logic [MAP_W-1:0]  base,
    input  logic [MAP_W-1:0]  map,
    input  logic [ADDR_W-1:0] addr,
    output xlat_t             res
);
    localparam int TOP_W = ADDR_W - IO_SHIFT;

    logic match;

    always_comb begin
        match = base[0] && (addr[ADDR_W-1:IO_SHIFT] == base[MAP_W-1:MAP_W-TOP_W]);
        res   = '0;
        if (match) begin
            res.hit   = 1'b1;
            res.addr  = {map[MAP_W-1:MAP_W-TOP_W], addr[IO_SHIFT-1:0]};
            res.cyc   = CYC_IO;
            res.adlow = 1'b1;
        end
    end

endmodule

// File: rtl/win_prio.sv
module win_prio
    import win_pkg::*;
#(
    parameter int NUM_WIN = 3
) (
    input  xlat_t [NUM_WIN-1:0] cand,
    output xlat_t               pick
);
    // Walk from the highest index down so the lowest matching index wins.
    always_comb begin
        pick = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cand[i].hit) pick = cand[i];
        end
    end

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
    import win_pkg::*;
#(
    parameter  int NUM_MEM_WIN = 2,
    localparam int NUM_WIN     = NUM_MEM_WIN + 1,
    localparam int SEL_W       = $clog2(2 * NUM_MEM_WIN + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              in_valid,
    input  logic [31:0]       in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [31:0]       out_addr,
    output logic [2:0]        out_type,
    output logic              out_adlow
);
    logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] mem_base;
    logic [NUM_MEM_WIN-1:0][MAP_W-1:0]  mem_map;
    logic [MAP_W-1:0]                   io_base;
    logic [MAP_W-1:0]                   io_map;
    xlat_t [NUM_WIN-1:0]                cand;
    xlat_t                              pick;
    xlat_t                              res_q;
    logic                               valid_q;

    win_regs #(.NUM_MEM(NUM_MEM_WIN), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .mem_base (mem_base),
        .mem_map  (mem_map),
        .io_base  (io_base),
        .io_map   (io_map)
    );

    for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mwin
        win_mem_match u_match (
            .base (mem_base[w]),
            .map  (mem_map[w]),
            .addr (in_addr),
            .res  (cand[w])
        );
    end

    win_io_match u_io (
        .base (io_base),
        .map  (io_map),
        .addr (in_addr),
        .res  (cand[NUM_WIN-1])
    );

    win_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .cand (cand),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            res_q   <= in_valid ? pick : '0;
        end
    end

    assign out_valid = valid_q;
    assign out_hit   = res_q.hit;
    assign out_addr  = res_q.addr;
    assign out_type  = res_q.cyc;
    assign out_adlow = res_q.adlow;

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_hit));
    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !out_hit |-> (out_addr == '0 && out_type == '0 && !out_adlow));
    assert_adlow_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (out_hit && !out_adlow) |-> (out_addr[1:0] == 2'b00));
    assert_adlow_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cand[0].hit && cand[0].adlow) |=>
            (out_hit && out_addr[1:0] == $past(in_addr[1:0])));
    assert_first_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cand[0].hit) |=> (out_addr == $past(cand[0].addr)));

endmodule

// File: tb/sim_addr_window_xlate.sv
module sim_addr_window_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid, out_hit, out_adlow;
    logic [31:0] out_addr;
    logic [2:0]  out_type;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addr_window_xlate u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_hit(out_hit), .out_addr(out_addr),
        .out_type(out_type), .out_adlow(out_adlow)
    );

    // Behavioural model state
    logic [31:0] m_base [2];
    logic [15:0] m_map  [2];
    logic [15:0] m_iob, m_iom;

    bit          have_pend = 0;
    bit          e_valid, e_hit, e_lo;
    logic [31:0] e_addr;
    logic [2:0]  e_type;
    string       e_tag;

    task automatic model(input logic [31:0] a, output bit hit,
                         output logic [31:0] pa, output logic [2:0] ty, output bit lo);
        longint la;
        la = longint'({32'b0, a});
        hit = 0; pa = '0; ty = '0; lo = 0;
        for (int w = 0; w < 2; w++) begin
            int     code;
            longint size, start, tgt;
            if (!hit && m_base[w][0]) begin
                code  = int'(m_base[w][7:4]);
                if (code > 11) code = 11;
                size  = longint'(1) << (20 + code);
                start = longint'(m_base[w][31:20]) * 1048576;
                start = start - (start % size);
                if (la >= start && la < start + size) begin
                    hit = 1;
                    tgt = longint'(m_map[w][15:4]) * 1048576;
                    tgt = tgt - (tgt % size);
                    pa  = 32'(tgt + (la % size));
                    ty  = m_map[w][3:1];
                    lo  = m_map[w][0];
                    if (!lo) pa = pa & 32'hFFFF_FFFC;
                end
            end
        end
        if (!hit && m_iob[0] && (la / 16777216) == longint'(m_iob[15:8])) begin
            hit = 1;
            pa  = 32'(longint'(m_iom[15:8]) * 16777216 + (la % 16777216));
            ty  = 3'b001;
            lo  = 1;
        end
    endtask

    task automatic check_pend();
        if (have_pend) begin
            checks++;
            if (out_valid !== e_valid || out_hit !== e_hit || out_addr !== e_addr ||
                out_type !== e_type || out_adlow !== e_lo) begin
                errors++;
                $display("FAIL %s: got v=%0b h=%0b a=%08h t=%03b lo=%0b exp v=%0b h=%0b a=%08h t=%03b lo=%0b",
                         e_tag, out_valid, out_hit, out_addr, out_type, out_adlow,
                         e_valid, e_hit, e_addr, e_type, e_lo);
            end
        end
    endtask

    task automatic cyc(input bit we, input int sel, input logic [31:0] d,
                       input bit v, input logic [31:0] a, input string tag);
        @(negedge clk);
        check_pend();
        reg_we = we; reg_sel = 3'(sel); reg_wdata = d; in_valid = v; in_addr = a;
        e_valid = v;
        if (v) model(a, e_hit, e_addr, e_type, e_lo);
        else begin e_hit = 0; e_addr = '0; e_type = '0; e_lo = 0; end
        e_tag = tag;
        have_pend = 1;
        if (we) begin
            case (sel)
                0: m_base[0] = d;
                1: m_map[0]  = d[15:0];
                2: m_base[1] = d;
                3: m_map[1]  = d[15:0];
                4: m_iob     = d[15:0];
                5: m_iom     = d[15:0];
                default: ;
            endcase
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d, input string tag);
        cyc(1, sel, d, 0, '0, tag);
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        cyc(0, 0, '0, 1, a, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < 2; w++) begin m_base[w] = '0; m_map[w] = '0; end
        m_iob = '0; m_iom = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1: got v=%0b h=%0b exp v=0 h=0", out_valid, out_hit);
        end
        rst = 1'b0;
        look(32'h4000_0000, "R1");
        look(32'h6000_0000, "R9");
        cyc(0, 0, '0, 0, 32'h4000_0000, "R2");

        // Window 0: 256 MB at 0x4000_0000, PCI 0x2000_0000, memory, low forced
        wr(0, 32'h4000_0081, "R10");
        wr(1, 32'hFFFF_2006, "R10");
        look(32'h4123_4567, "R4");
        look(32'h4FFF_FFFF, "R3");
        look(32'h3FFF_FFFF, "R3");
        look(32'h5000_0000, "R3");
        look(32'h4000_0003, "R6");

        // Window 1: 256 MB at 0x5000_0000, config type, low passed
        wr(2, 32'h5000_0089, "R10");
        wr(3, 32'h0000_000B, "R10");
        look(32'h5000_1237, "R6");
        look(32'h5FFF_FFFE, "R5");

        // Enlarge window 0 to 512 MB: it hides window 1
        wr(0, 32'h4000_0091, "R7");
        look(32'h5000_1237, "R7");
        look(32'h5FFF_FFFF, "R7");
        // Shrink back with stray low base bits
        wr(0, 32'h4560_0081, "R3");
        look(32'h5000_1237, "R7");
        look(32'h4560_0000, "R3");
        look(32'h4000_0010, "R3");

        // Disable window 0
        wr(0, 32'h4000_0080, "R9");
        look(32'h4100_0000, "R9");

        // I/O window at 0x60xx_xxxx -> 0x12xx_xxxx
        wr(4, 32'hFFFF_6001, "R8");
        wr(5, 32'h0000_1200, "R8");
        look(32'h60AB_CDEF, "R8");
        look(32'h6100_0000, "R8");
        look(32'h5FFF_FFFF, "R8");

        // Size code 15 acts as 2 GB
        wr(0, 32'h8000_00F1, "R3");
        wr(1, 32'h0000_100C, "R5");
        look(32'h9234_5678, "R3");
        look(32'h0000_1000, "R3");
        look(32'hFFFF_FFFF, "R3");

        // 1 MB interrupt acknowledge window
        wr(2, 32'h0010_0001, "R5");
        wr(3, 32'h0000_ABC0, "R5");
        look(32'h001F_FFFF, "R5");
        look(32'h0020_0000, "R5");

        // Write and lookup in the same cycle use old contents
        cyc(1, 2, 32'h0000_0000, 1, 32'h0010_0004, "R10");
        look(32'h0010_0004, "R10");

        // Random sweep around edges with reprogramming
        wr(0, 32'h4000_0071, "R7");
        wr(1, 32'h0000_3007, "R7");
        wr(2, 32'h4400_0061, "R7");
        wr(3, 32'h0000_8003, "R7");
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            a = $urandom;
            case (k % 4)
                0: a = {8'h40, a[23:0]};
                1: a = {8'h44, a[23:0]};
                2: a = {8'h60, a[23:0]};
                default: ;
            endcase
            if (k % 9 == 0) cyc(0, 0, '0, 0, a, "R2");
            else look(a, "R7");
        end
        cyc(0, 0, '0, 0, '0, "R2");
        @(negedge clk);
        check_pend();
        have_pend = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule